// File: doc/BRIEF.md
# Periodic System Tick Timer

A down-counting periodic timer for a processor subsystem, with a small word-addressed register port. Software programs a reload value, selects where the count pulses come from, and enables counting. The counter walks down to zero. On the next count pulse it reloads and keeps going, so a reload value of N gives a period of N+1 pulses. Each time the counter steps from one to zero, it sets a sticky wrap flag. If the tick interrupt is enabled, it also emits a one-cycle request.

Count pulses come from one of two sources. The first is every core clock. The second is a synchronized rising edge of an external reference input. While a debug-halt input is high, the count holds its value. When the build parameter says no reference input exists, the source bit is fixed at "core clock" and resets that way. The bus port is single-cycle: read data is combinational from the address, and writes take effect at the clock edge.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status, reload and current-value registers all read 0 and `tick_irq` is low (when `HAS_REF`=1).
- R2: With enable=1, source=1 (core clock) and no halt, the current value drops by one on every clock edge while it is nonzero.
- R3: On a count pulse with the current value at zero, the counter loads the reload value. A reload value of zero keeps it at zero.
- R4: While `dbg_halt` is high, the current value does not change.
- R5: Byte offset 0x0 is control/status, 0x4 is reload, 0x8 is current value and 0xC is calibration. Calibration reads the `CAL_WORD` parameter, and writes to it have no effect.
- R6: Control/status reads {15'b0, wrap flag at bit 16, 13'b0, source at bit 2, interrupt enable at bit 1, enable at bit 0}. Writes affect only bits 2:0. Reload keeps only bits 23:0, and bits 31:24 read 0.
- R7: The wrap flag is set when a count pulse takes the value from 1 to 0. A control/status read returns the flag and then clears it, unless a new wrap happens in that same cycle.
- R8: Any write to the current-value register sets it to zero and clears the wrap flag, whatever the write data.
- R9: `tick_irq` is high for exactly one cycle: the cycle after the edge that takes the count from 1 to 0. This happens only if the interrupt enable was 1.
- R10: With source=0, the counter steps once per rising edge of `ref_tick_in`, after a two-flop synchronizer. It does not step on ordinary clocks or while the input is held high.
- R11: With `HAS_REF`=0, control/status resets to 0x00000004 and the source bit always reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, 0 when not reading |
| ref_tick_in | input | 1 | External reference tick, asynchronous |
| dbg_halt | input | 1 | Freezes the counter while high |
| tick_irq | output | 1 | One-cycle tick request |

## Verification
Read data is due in the same cycle as the access. The bench samples it 1 ns after driving the address, on the falling half of the clock. Register writes and count steps become visible after the next rising edge, and `tick_irq` is high for the cycle after the edge that reaches zero. The bench's model therefore advances once per rising edge, and its prediction is compared at the following falling edge. Reference-tick steps pass through two synchronizer flops and an edge detector, so they land two to three cycles after the input rises. The bench checks these by counting steps only after waiting well past that window.

// File: rtl/tick_pkg.sv
package tick_pkg;
   localparam int unsigned BUS_W = 32;

   // word index (byte offset >> 2) of each register
   localparam logic [1:0] IDX_CTRL   = 2'd0;
   localparam logic [1:0] IDX_RELOAD = 2'd1;
   localparam logic [1:0] IDX_COUNT  = 2'd2;
   localparam logic [1:0] IDX_CAL    = 2'd3;

   // control/status field positions
   localparam int unsigned POS_EN   = 0;
   localparam int unsigned POS_IE   = 1;
   localparam int unsigned POS_SRC  = 2;
   localparam int unsigned POS_WRAP = 16;

   typedef struct packed {
      logic src;
      logic ie;
      logic en;
   } ctl_t;
endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tick_ref_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], async_in};
   end

   assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/tick_regs.sv
module tick_regs
   import tick_pkg::*;
#(
   parameter int unsigned CNT_W    = 24,
   parameter bit          HAS_REF  = 1'b1,
   parameter logic [31:0] CAL_WORD = 32'h0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [3:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wrap,
   output ctl_t             ctl,
   output logic [CNT_W-1:0] reload,
   output logic [31:0]      rdata,
   output logic             cnt_clr,
   output logic             stat_rd
);
   localparam int unsigned PAD_W = BUS_W - CNT_W;

   logic [1:0] widx;
   logic       wr_ctrl, wr_reload, rd_any;
   logic       en_q, ie_q, src_q;

   assign widx      = bus_addr[3:2];
   assign rd_any    = bus_sel & ~bus_wr;
   assign wr_ctrl   = bus_sel & bus_wr & (widx == IDX_CTRL);
   assign wr_reload = bus_sel & bus_wr & (widx == IDX_RELOAD);
   assign cnt_clr   = bus_sel & bus_wr & (widx == IDX_COUNT);
   assign stat_rd   = rd_any & (widx == IDX_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         ie_q   <= 1'b0;
         reload <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q <= bus_wdata[POS_EN];
            ie_q <= bus_wdata[POS_IE];
         end
         if (wr_reload) reload <= bus_wdata[CNT_W-1:0];
      end
   end

   if (HAS_REF) begin : g_src_sel
      always_ff @(posedge clk) begin
         if (!rst_n)       src_q <= 1'b0;
         else if (wr_ctrl) src_q <= bus_wdata[POS_SRC];
      end
   end else begin : g_src_fixed
      assign src_q = 1'b1;
   end

   assign ctl = '{src: src_q, ie: ie_q, en: en_q};

   always_comb begin
      rdata = '0;
      if (rd_any) begin
         case (widx)
            IDX_CTRL: begin
               rdata[POS_EN]   = en_q;
               rdata[POS_IE]   = ie_q;
               rdata[POS_SRC]  = src_q;
               rdata[POS_WRAP] = wrap;
            end
            IDX_RELOAD: rdata = {{PAD_W{1'b0}}, reload};
            IDX_COUNT:  rdata = {{PAD_W{1'b0}}, cnt};
            default:    rdata = CAL_WORD;
         endcase
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:CNT_W]};
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             clear,
   input  logic             stat_rd,
   input  logic             ie,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output logic             irq
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic hit;
   assign hit = step & (cnt == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         wrap <= 1'b0;
         irq  <= 1'b0;
      end else if (clear) begin
         cnt  <= '0;
         wrap <= 1'b0;
         irq  <= 1'b0;
      end else begin
         if (step) cnt <= (cnt == '0) ? reload : cnt - ONE;
         if (hit)          wrap <= 1'b1;
         else if (stat_rd) wrap <= 1'b0;
         irq <= hit & ie;
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_pkg::*;
#(
   parameter int unsigned CNT_W     = 24,
   parameter bit          HAS_REF   = 1'b1,
   parameter int unsigned SYNC_STG  = 2,
   parameter logic [31:0] CAL_WORD  = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [3:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        ref_tick_in,
   input  logic        dbg_halt,
   output logic        tick_irq
);
   if (CNT_W < 8 || CNT_W > 24) begin : g_bad_width
      $error("tick_timer: CNT_W must lie in 8..24");
   end

   ctl_t             ctl;
   logic [CNT_W-1:0] reload, cnt_q;
   logic             wrap_q, cvr_wr, stat_rd, ref_rise, step;

   tick_ref_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ref_tick_in),
      .rise     (ref_rise)
   );

   tick_regs #(.CNT_W(CNT_W), .HAS_REF(HAS_REF), .CAL_WORD(CAL_WORD)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cnt       (cnt_q),
      .wrap      (wrap_q),
      .ctl       (ctl),
      .reload    (reload),
      .rdata     (bus_rdata),
      .cnt_clr   (cvr_wr),
      .stat_rd   (stat_rd)
   );

   assign step = ctl.en & ~dbg_halt & (ctl.src | ref_rise);

   tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .clear   (cvr_wr),
      .stat_rd (stat_rd),
      .ie      (ctl.ie),
      .reload  (reload),
      .cnt     (cnt_q),
      .wrap    (wrap_q),
      .irq     (tick_irq)
   );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int unsigned CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step,
   input logic             clear,
   input logic             dbg_halt,
   input logic [CNT_W-1:0] cnt_q,
   input logic             wrap_q,
   input logic             tick_irq,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [3:0]       bus_addr,
   input logic [31:0]      bus_rdata
);
   // R2
   dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_q != '0 && !clear) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R4
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halt && !clear) |=> $stable(cnt_q));

   // R9
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |=> !tick_irq);

   // R9
   irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |-> (cnt_q == '0));

   // R7
   irq_flags_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |-> wrap_q);

   // R7
   wrap_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wrap_q) |-> (cnt_q == '0));

   // R6
   reload_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr[3:2] == 2'd1) |-> (bus_rdata[31:24] == 8'h0));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step      (step),
   .clear     (cvr_wr),
   .dbg_halt  (dbg_halt),
   .cnt_q     (cnt_q),
   .wrap_q    (wrap_q),
   .tick_irq  (tick_irq),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
   localparam logic [31:0] CAL = 32'h4012_3456;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, rdata_nr;
   logic        ref_tick_in = 1'b0, dbg_halt = 1'b0;
   logic        tick_irq, irq_nr;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   // bench model state
   logic [23:0] m_cnt = '0, m_rvr = '0;
   logic        m_en = 0, m_ie = 0, m_src = 0, m_wrap = 0, m_irq = 0;

   always #5 clk = ~clk;

   tick_timer #(.CAL_WORD(CAL)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ref_tick_in(ref_tick_in), .dbg_halt(dbg_halt), .tick_irq(tick_irq));

   tick_timer #(.HAS_REF(1'b0), .CAL_WORD(CAL)) dut_noref (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_nr),
      .ref_tick_in(ref_tick_in), .dbg_halt(dbg_halt), .tick_irq(irq_nr));

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      case (a[3:2])
         2'd0:    return {15'b0, m_wrap, 13'b0, m_src, m_ie, m_en};
         2'd1:    return {8'b0, m_rvr};
         2'd2:    return {8'b0, m_cnt};
         default: return CAL;
      endcase
   endfunction

   // one bus cycle, entered and left at a falling edge
   task automatic op(input bit sel, input bit wr, input logic [3:0] a,
                     input logic [31:0] wd, input bit halt, input string req);
      bit step, hit;
      bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd; dbg_halt = halt;
      #1;
      if (sel && !wr) check(bus_rdata, exp_read(a), req);
      @(posedge clk);
      step = m_en && !halt && m_src;
      hit = 1'b0;
      if (sel && wr && a[3:2] == 2'd2) begin
         m_cnt = '0; m_wrap = 0; m_irq = 0;
      end else begin
         if (step) begin
            if (m_cnt == 0) m_cnt = m_rvr;
            else begin
               if (m_cnt == 1) hit = 1'b1;
               m_cnt = m_cnt - 1;
            end
         end
         if (hit) m_wrap = 1;
         else if (sel && !wr && a[3:2] == 2'd0) m_wrap = 0;
         m_irq = hit && m_ie;
      end
      if (sel && wr && a[3:2] == 2'd0) begin
         m_en = wd[0]; m_ie = wd[1]; m_src = wd[2];
      end
      if (sel && wr && a[3:2] == 2'd1) m_rvr = wd[23:0];
      @(negedge clk);
      check({31'b0, tick_irq}, {31'b0, m_irq}, "R9");
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [3:0] a, input string req) ;
      op(1, 0, a, 32'h0, 0, req);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      op(1, 1, a, d, 0, "wr");
   endtask

   task automatic idle(input int n, input bit halt);
      for (int i = 0; i < n; i++) op(0, 0, 4'h0, 32'h0, halt, "idle");
   endtask

   task automatic raw_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic raw_rd(input logic [3:0] a, output logic [31:0] v, output logic [31:0] v_nr);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1; v = bus_rdata; v_nr = rdata_nr;
      @(negedge clk);
      bus_sel = 0;
   endtask

   initial begin : watchdog
      #(10 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v, vn;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state, R11 no-reference variant
      #1;
      bus_sel = 1; bus_addr = 4'h0; #1;
      check(rdata_nr, 32'h4, "R11");
      bus_sel = 0;
      rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1");
      check({31'b0, tick_irq}, 32'h0, "R1");

      // R5 calibration read and write ignored
      rd(4'hC, "R5");
      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'hC, "R5");

      // R6 field masks
      wr(4'h4, 32'hFFFF_FFFF);
      rd(4'h4, "R6");
      wr(4'h0, 32'hFFFF_FFF8);
      rd(4'h0, "R6");

      // R2 R3 R9 R7: reload 3, count down with interrupts
      wr(4'h4, 32'd3);
      wr(4'h8, 32'h0);
      wr(4'h0, 32'h7);
      for (int i = 0; i < 9; i++) rd(4'h8, "R2");
      rd(4'h0, "R7");
      rd(4'h0, "R7");

      // R4 halt freezes
      idle(5, 1'b1);
      rd(4'h8, "R4");
      idle(2, 1'b1);
      rd(4'h8, "R4");

      // R8 clear by write, data ignored
      wr(4'h8, 32'hFFFF_FFFF);
      rd(4'h8, "R8");
      rd(4'h0, "R8");

      // R3 reload of zero sticks at zero
      wr(4'h4, 32'd0);
      idle(4, 1'b0);
      for (int i = 0; i < 4; i++) rd(4'h8, "R3");

      // constrained random phase (reference input held low)
      for (int i = 0; i < 3000; i++) begin
         int k;
         logic [3:0] a;
         logic [31:0] d;
         bit h;
         k = $urandom_range(0, 99);
         a = 4'($urandom_range(0, 3) << 2);
         h = ($urandom_range(0, 9) < 2);
         if (k < 35) op(0, 0, 4'h0, 32'h0, h, "R2");
         else if (k < 75) op(1, 0, a, 32'h0, h, "R7");
         else if (k < 85) op(1, 1, 4'h4, 32'($urandom_range(0, 6)), h, "R3");
         else if (k < 92) op(1, 1, 4'h0, {$urandom} | 32'h1, h, "R6");
         else if (k < 96) op(1, 1, 4'h8, $urandom, h, "R8");
         else op(1, 1, 4'hC, $urandom, h, "R5");
      end

      // R10 reference-tick source
      raw_wr(4'h0, 32'h0);
      raw_wr(4'h8, 32'h0);
      raw_wr(4'h4, 32'd10);
      repeat (4) @(negedge clk);
      raw_wr(4'h0, 32'h1);
      repeat (10) @(negedge clk);
      raw_rd(4'h8, v, vn);
      check(v, 32'd0, "R10");
      for (int p = 0; p < 3; p++) begin
         ref_tick_in = 1;
         repeat (5) @(negedge clk);
         ref_tick_in = 0;
         repeat (5) @(negedge clk);
      end
      raw_rd(4'h8, v, vn);
      check(v, 32'd8, "R10");
      ref_tick_in = 1;
      repeat (30) @(negedge clk);
      raw_rd(4'h8, v, vn);
      check(v, 32'd7, "R10");
      ref_tick_in = 0;

      // R11 source bit fixed in the no-reference variant
      raw_wr(4'h0, 32'h0);
      raw_rd(4'h0, v, vn);
      raw_rd(4'h0, v, vn);
      check(vn, 32'h4, "R11");

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule